// File: doc/BRIEF.md
# Serial Identity Code CRC-8 Unit

This block computes and verifies the 8-bit cyclic redundancy check that protects a 64-bit device identity code. The code is made of an 8-bit family field in the low byte, a 48-bit serial field above it, and an 8-bit check byte in the top byte. The engine is a reflected shift register for the polynomial x^8 + x^5 + x^4 + 1. It takes one bit per clock when a strobe is high, least significant bit first, and always shows its running remainder.

The unit can be used in two ways. In serial use, the surrounding logic feeds bits directly. After 56 bits the remainder is the check byte to append. After all 64 bits, a zero remainder means the code is intact. In parallel use, a whole 64-bit word is loaded in one cycle. A feeder then shifts it into the engine, bit 0 first, over 64 cycles. A done flag and a pass flag give the verdict. Validity is judged by a zero residue, not by comparing the computed byte with the stored one.

Top module: `id_crc_unit`

## Requirements
- R1: After reset, `remainder` is 0, `bit_count` is 0, and `done`, `crc_ok` and `busy` are 0.
- R2: Each accepted bit `b` updates the remainder `r` as follows. Let `f = b ^ r[0]`. The new `r` is `r >> 1`, XORed with 8'h8C when `f` is 1 (taps at bits 7, 3 and 2).
- R3: `bit_count` rises by one for each accepted bit. `done` is 1 exactly when `bit_count` equals 64.
- R4: Bits are fed in this order: family bits 0..7, then serial bits 0..47. After these 56 bits, `remainder` equals the check byte of the code.
- R5: `crc_ok` is 1 when `done` is 1 and the remainder is zero. A code whose top byte is its correct check byte gives `crc_ok`=1. A code with any single flipped bit gives `crc_ok`=0.
- R6: Once `done` is 1, further strobes change neither `remainder` nor `bit_count`.
- R7: `clr` zeroes the remainder and the count. When `clr` and `bit_vld` are high in the same cycle, the clear wins: the count and remainder read 0 afterwards.
- R8: A `load` pulse while idle captures `code_in`. It raises `busy` for exactly 64 cycles and feeds bit 0 first. At the end, `done` is 1 and `crc_ok` gives the verdict for that word.
- R9: A `load` pulse while `busy` is 1 is ignored. The verdict is that of the word already being shifted.
- R10: While `busy` is 1, `bit_vld` and `bit_in` are ignored.
- R11: An accepted `load` clears the engine, so any earlier partial serial run does not affect the verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of engine and feeder |
| bit_vld | input | 1 | Serial bit strobe |
| bit_in | input | 1 | Serial data bit |
| load | input | 1 | Parallel load request |
| code_in | input | 64 | Parallel identity code, bit 0 shifted first |
| busy | output | 1 | Feeder is shifting a loaded word |
| remainder | output | 8 | Running CRC remainder |
| bit_count | output | 7 | Bits accepted since last clear |
| done | output | 1 | 64 bits accepted |
| crc_ok | output | 1 | Done with zero residue |

## Verification
Two pairs of events can land in the same cycle. The first is a clear together with a serial strobe. The bench drives `clr` and `bit_vld` with a one-bit together in the middle of a run, then checks that count and remainder read zero. The second is a load request while the feeder is already shifting. The bench pulses `load` with a corrupted word partway through a valid word's shift, and toggles the serial strobe in the same window. It then checks that `busy` lasted 64 cycles and that the verdict is the valid one.

// File: rtl/id_crc_pkg.sv
// Shared constants and the single-bit step of the reflected CRC-8.
// Assumes bits are presented least significant first.
package id_crc_pkg;
    localparam int CODE_W   = 64;
    localparam int CRC_W    = 8;
    localparam int DATA_W   = CODE_W - CRC_W;
    localparam int CNT_W    = $clog2(CODE_W + 1);
    localparam logic [CRC_W-1:0] POLY_REF = 8'h8C;

    // One shift of the reflected register with the incoming bit.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] r,
                                                   input logic b);
        logic fb;
        fb = b ^ r[0];
        return (r >> 1) ^ (fb ? POLY_REF : '0);
    endfunction
endpackage

// File: rtl/id_crc_engine.sv
// Bit-serial CRC engine. Accepts one bit per strobe until CODE_W bits are in,
// then freezes. Clear beats strobe. Assumes synchronous active-low reset.
module id_crc_engine
    import id_crc_pkg::*;
#(
    parameter int TOTAL_BITS = CODE_W,
    parameter int RW         = CRC_W,
    localparam int CW        = $clog2(TOTAL_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          bit_vld,
    input  logic          bit_in,
    output logic [RW-1:0] remainder,
    output logic [CW-1:0] bit_count,
    output logic          done,
    output logic          crc_ok
);
    logic [RW-1:0] rem_q;
    logic [CW-1:0] cnt_q;
    logic          full;

    assign full = (cnt_q == CW'(TOTAL_BITS));

    // Update remainder and count on reset, clear, or an accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            rem_q <= '0;
            cnt_q <= '0;
        end else if (bit_vld && !full) begin
            rem_q <= crc_step(rem_q, bit_in);
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expose state and verdict.
    always_comb begin
        remainder = rem_q;
        bit_count = cnt_q;
        done      = full;
        crc_ok    = full && (rem_q == '0);
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rem_q == '0 && cnt_q == '0)); // R7
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(TOTAL_BITS)); // R3
    AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !clr && !full) |=> cnt_q == CW'($past(cnt_q) + 1'b1)); // R3
    AST_FROZEN_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> ($stable(rem_q) && $stable(cnt_q))); // R6
endmodule

// File: rtl/id_code_feeder.sv
// Parallel-load front end. Captures a word when idle and shifts it out LSB
// first, one bit per cycle, for CODE_W cycles. Loads while busy are dropped.
module id_code_feeder
    import id_crc_pkg::*;
#(
    parameter int W   = CODE_W,
    localparam int LW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] code_in,
    output logic         accept,
    output logic         busy,
    output logic         feed_bit
);
    logic [W-1:0]  shreg;
    logic [LW-1:0] left;

    // A load is taken only when idle and not being cleared.
    assign accept   = load && !busy && !clr;
    assign feed_bit = shreg[0];

    // Capture, shift and count down the remaining bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
            busy  <= 1'b0;
        end else if (clr) begin
            left  <= '0;
            busy  <= 1'b0;
        end else if (accept) begin
            shreg <= code_in;
            left  <= LW'(W);
            busy  <= 1'b1;
        end else if (busy) begin
            shreg <= shreg >> 1;
            left  <= left - 1'b1;
            if (left == LW'(1)) busy <= 1'b0;
        end
    end

    AST_BUSY_IGNORES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load && !clr) |=> left == LW'($past(left) - 1'b1)); // R9
    AST_IDLE_HAS_NO_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> left == '0); // R8
endmodule

// File: rtl/id_crc_unit.sv
// Top level: serial CRC engine plus parallel feeder. While the feeder is
// busy it owns the engine input; an accepted load also clears the engine.
module id_crc_unit
    import id_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    output logic              busy,
    output logic [CRC_W-1:0]  remainder,
    output logic [CNT_W-1:0]  bit_count,
    output logic              done,
    output logic              crc_ok
);
    logic accept, feed_bit, eng_clr, eng_vld, eng_bit;

    id_code_feeder #(.W(CODE_W)) u_feeder (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .code_in(code_in),
        .accept(accept), .busy(busy), .feed_bit(feed_bit)
    );

    // Select engine input: feeder while busy, serial port otherwise.
    always_comb begin
        eng_clr = clr | accept;
        eng_vld = busy ? 1'b1 : bit_vld;
        eng_bit = busy ? feed_bit : bit_in;
    end

    id_crc_engine #(.TOTAL_BITS(CODE_W), .RW(CRC_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .clr(eng_clr), .bit_vld(eng_vld),
        .bit_in(eng_bit), .remainder(remainder), .bit_count(bit_count),
        .done(done), .crc_ok(crc_ok)
    );

    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy && !clr) |=> (busy && bit_count == '0)); // R11
endmodule

// File: tb/id_crc_unit_bench.sv
module id_crc_unit_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        clr = 0, bit_vld = 0, bit_in = 0, load = 0;
    logic [63:0] code_in = '0;
    logic        busy, done, crc_ok;
    logic [7:0]  remainder;
    logic [6:0]  bit_count;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk; // 50 MHz

    id_crc_unit u_id_crc_unit (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_vld(bit_vld), .bit_in(bit_in),
        .load(load), .code_in(code_in), .busy(busy), .remainder(remainder),
        .bit_count(bit_count), .done(done), .crc_ok(crc_ok)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [63:0] w, input int n);
        logic [7:0] r = 0;
        for (int i = 0; i < n; i++) begin
            logic f = w[i] ^ r[0];
            r = {1'b0, r[7:1]};
            if (f) r = r ^ 8'h8C;
        end
        return r;
    endfunction

    function automatic logic [63:0] make_code(input logic [55:0] d);
        return {ref_crc({8'h0, d}, 56), d};
    endfunction

    task automatic do_clear();
        @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    endtask

    task automatic shift_bits(input logic [63:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_vld = 1; bit_in = w[i];
        end
        @(negedge clk); bit_vld = 0; bit_in = 0;
    endtask

    task automatic t_reset();
        chk("R1 remainder", remainder, 0);
        chk("R1 count", bit_count, 0);
        chk("R1 done", done, 0);
        chk("R1 ok", crc_ok, 0);
        chk("R1 busy", busy, 0);
    endtask

    task automatic t_step();
        do_clear();
        shift_bits(64'h1, 1);
        chk("R2 one-bit step", remainder, 8'h8C);
        shift_bits(64'h0, 1);
        chk("R2 zero-bit step", remainder, 8'h46);
        chk("R3 count two", bit_count, 2);
    endtask

    task automatic t_known();
        do_clear();
        shift_bits(64'hA2000000_01B81C02, 56);
        chk("R4 known check byte", remainder, 8'hA2);
        chk("R3 count 56", bit_count, 56);
        chk("R3 not done", done, 0);
        shift_bits(64'hA2000000_01B81C02 >> 56, 8);
        chk("R3 done at 64", done, 1);
        chk("R5 known valid", crc_ok, 1);
    endtask

    task automatic t_generate(input logic [55:0] d);
        do_clear();
        shift_bits({8'h0, d}, 56);
        chk("R4 generated byte", remainder, ref_crc({8'h0, d}, 56));
    endtask

    task automatic t_extra();
        logic [63:0] w = make_code(56'h00_1234_5678_9A_3C);
        do_clear();
        shift_bits(w, 64);
        shift_bits(64'hFFFF, 5);
        chk("R6 count frozen", bit_count, 64);
        chk("R6 remainder frozen", remainder, 0);
        chk("R5 still ok", crc_ok, 1);
    endtask

    task automatic t_clear_prio();
        do_clear();
        shift_bits(64'h5A, 10);
        @(negedge clk); clr = 1; bit_vld = 1; bit_in = 1;
        @(negedge clk); clr = 0; bit_vld = 0; bit_in = 0;
        chk("R7 count cleared", bit_count, 0);
        chk("R7 remainder cleared", remainder, 0);
    endtask

    task automatic run_load(input logic [63:0] w, input bit disturb,
                            input logic [63:0] w2, output int busy_cycles);
        int guard = 0;
        busy_cycles = 0;
        @(negedge clk); load = 1; code_in = w;
        @(negedge clk); load = 0;
        while (busy && guard < 200) begin
            if (busy) busy_cycles++;
            if (disturb && busy_cycles == 10) begin load = 1; code_in = w2; end
            else if (disturb && busy_cycles == 11) load = 0;
            if (disturb && busy_cycles > 20 && busy_cycles < 30) begin
                bit_vld = 1; bit_in = busy_cycles[0];
            end else begin
                bit_vld = 0; bit_in = 0;
            end
            @(negedge clk); guard++;
        end
        load = 0; bit_vld = 0; bit_in = 0;
    endtask

    task automatic t_load();
        int bc;
        logic [63:0] good = make_code(56'hC0_FFEE_0011_22_28);
        run_load(good, 0, 0, bc);
        chk("R8 busy span", bc, 64);
        chk("R8 done", done, 1);
        chk("R8 valid verdict", crc_ok, 1);
        run_load(good ^ 64'h0000_0100_0000_0000, 0, 0, bc);
        chk("R5 corrupted verdict", crc_ok, 0);
        chk("R8 done corrupted", done, 1);
    endtask

    task automatic t_busy_ignores();
        int bc;
        logic [63:0] good = make_code(56'h00_0000_0001_B8_1D);
        run_load(good, 1, good ^ 64'h1, bc);
        chk("R9 load ignored span", bc, 64);
        chk("R9 R10 verdict kept", crc_ok, 1);
    endtask

    task automatic t_load_clears();
        int bc;
        logic [63:0] good = make_code(56'h77_6655_4433_22_11);
        do_clear();
        shift_bits(64'hDEAD, 13);
        run_load(good, 0, 0, bc);
        chk("R11 count after load", bit_count, 64);
        chk("R11 verdict", crc_ok, 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                t_reset();
                t_step();
                t_known();
                t_generate(56'h12_3456_789A_BC_01);
                t_generate(56'hFF_FFFF_FFFF_FF_FF);
                t_generate(56'h80_0000_0000_00_00);
                t_extra();
                t_clear_prio();
                t_load();
                t_busy_ignores();
                t_load_clears();
            end
            begin
                repeat (50000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule